// File: doc/BRIEF.md
# Prescaled Up-Counting Time Base

This block is a 16-bit up-counting time base. An input clock first passes through a programmable 16-bit divider. The divided tick advances a counter that wraps back to zero when it reaches a programmable reload limit. Each wrap issues a one-cycle update pulse. Software can also force an update with a strobe, and an external trigger in reset mode can force one too.

The divider ratio is double-buffered. Writes go to a pending copy, and the working divider adopts that copy only at an update event. This lets software change the tick rate without a glitch in mid-period. A reload limit of zero freezes the whole time base.

Three 16-bit registers are reachable through a small write-strobe and address interface: the counter, the pending divider value and the reload limit. Reads are combinational.

Top module: `pscl_timebase`

## Requirements
- R1: After reset, the counter, divider and reload registers all read 0x0000, and the update output is low.
- R2: With a non-zero reload limit and an active divider value P, the counter advances once every P+1 clock cycles. P = 0 means it advances on every cycle.
- R3: A write at address 1 sets the pending divider value. Reads at address 1 return that pending value. The active divider changes only on a clock edge that also sets the update output.
- R4: On a counter tick where the counter equals the reload limit, the counter becomes 0. The update output is then high for exactly the following cycle.
- R5: A high `ug_i` clears the counter and the divider phase and loads the pending divider value into the active divider. The update output is high in the following cycle.
- R6: A high `trig_i` has the same effect as `ug_i`.
- R7: While the reload limit is 0, neither the counter nor the divider phase advances.
- R8: A write at address 0 sets the counter on the next edge. It raises no update and leaves the active divider unchanged. A simultaneous `ug_i` or `trig_i` overrides it and clears the counter.
- R9: A write at address 2 sets the reload limit. The new limit governs comparisons from the next cycle on.
- R10: Address 3 reads 0x0000, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 counter, 1 divider, 2 reload, 3 unused |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for `addr_i` |
| ug_i | input | 1 | Software update-generate strobe |
| trig_i | input | 1 | Reset-mode trigger |
| upd_o | output | 1 | One-cycle update pulse |

## Verification
The assertions assume that `ug_i` and `trig_i` are synchronous to `clk` and free of unknown values. They also assume that a counter write is meant to lose against a simultaneous forced update. The bench drives every input on the falling edge, so each input is stable across the rising edge. The random mix keeps reload limits small (including zero) and divider values between 0 and 3. This produces many wraps and ratio changes, and it lets strobes, triggers and register writes collide in the same cycle.

// File: rtl/pscl_timebase.sv
module pscl_timebase #(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic          ug_i,
  input  logic          trig_i,
  output logic          upd_o
);
  localparam logic [AW-1:0] A_CNT = AW'(0);
  localparam logic [AW-1:0] A_PSC = AW'(1);
  localparam logic [AW-1:0] A_ARR = AW'(2);

  logic [W-1:0] cnt, psc_pre, psc_act, pc, arr;

  wire run      = |arr;
  wire force_ev = ug_i | trig_i;
  wire cnt_wr   = wr_i && addr_i == A_CNT;
  wire tick     = run && pc == psc_act;
  wire wrap     = tick && cnt == arr && !cnt_wr && !force_ev;
  wire ev       = force_ev | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; psc_pre <= '0; psc_act <= '0; pc <= '0; arr <= '0; upd_o <= 1'b0;
    end else begin
      upd_o <= ev;
      if (ev) psc_act <= psc_pre;
      if (wr_i && addr_i == A_PSC) psc_pre <= wdata_i;
      if (wr_i && addr_i == A_ARR) arr <= wdata_i;
      if (force_ev)  pc <= '0;
      else if (run)  pc <= tick ? '0 : pc + 1'b1;
      if (force_ev)    cnt <= '0;
      else if (cnt_wr) cnt <= wdata_i;
      else if (tick)   cnt <= (cnt == arr) ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CNT:   rdata_o = cnt;
      A_PSC:   rdata_o = psc_pre;
      A_ARR:   rdata_o = arr;
      default: rdata_o = '0;
    endcase
  end

  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0 && upd_o)); // R4
  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    force_ev |=> (cnt == '0 && pc == '0 && upd_o)); // R5
  AST_PSC_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(psc_act) |-> upd_o); // R3
  AST_ZERO_ARR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (arr == '0 && !force_ev && !cnt_wr) |=> ($stable(cnt) && $stable(pc))); // R7
  AST_CNT_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !force_ev) |=> (cnt == $past(wdata_i) && !upd_o)); // R8
endmodule

// File: tb/pscl_timebase_tb.sv
module pscl_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        ug_i = 1'b0, trig_i = 1'b0;
  logic        upd_o;

  int checks = 0, fails = 0;
  string req = "R1";

  always #2 clk = ~clk;

  pscl_timebase u_dut (.clk(clk), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ug_i(ug_i), .trig_i(trig_i), .upd_o(upd_o));

  // Reference model of the requirements
  logic [15:0] m_cnt, m_pp, m_pa, m_pc, m_arr;
  logic        m_upd;

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_pp;
      2'd2: return m_arr;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pp = 0; m_pa = 0; m_pc = 0; m_arr = 0; m_upd = 0;
    end else begin
      logic frc, cw, tk, ovf;
      logic [15:0] n_cnt, n_pp, n_pa, n_pc, n_arr;
      frc = ug_i | trig_i;
      cw  = wr_i && addr_i == 2'd0;
      tk  = (m_arr != 0) && (m_pc == m_pa);
      ovf = tk && m_cnt == m_arr && !cw && !frc;
      n_pa  = (frc || ovf) ? m_pp : m_pa;
      n_pp  = (wr_i && addr_i == 2'd1) ? wdata_i : m_pp;
      n_arr = (wr_i && addr_i == 2'd2) ? wdata_i : m_arr;
      n_pc  = frc ? 16'h0 : (m_arr == 0) ? m_pc : tk ? 16'h0 : m_pc + 16'h1;
      n_cnt = frc ? 16'h0 : cw ? wdata_i : !tk ? m_cnt : (m_cnt == m_arr) ? 16'h0 : m_cnt + 16'h1;
      m_upd = frc || ovf;
      m_cnt = n_cnt; m_pp = n_pp; m_pa = n_pa; m_pc = n_pc; m_arr = n_arr;
    end
  end

  task automatic check(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic w, input logic [1:0] a, input logic [15:0] d,
                     input logic u, input logic t);
    wr_i = w; addr_i = a; wdata_i = d; ug_i = u; trig_i = t;
    @(negedge clk);
    check(req, rdata_o, exp_rd(a));
    check({req, " upd"}, {15'h0, upd_o}, {15'h0, m_upd});
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) cyc(0, a, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int pulses;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    req = "R1";
    check("R1 cnt", rdata_o, 16'h0);
    check("R1 upd", {15'h0, upd_o}, 16'h0);
    rst_n = 1'b1;
    cyc(0, 2'd1, 0, 0, 0);
    cyc(0, 2'd2, 0, 0, 0);
    req = "R7"; idle(6, 2'd0);
    check("R7 stalled cnt", rdata_o, 16'h0);
    req = "R9"; cyc(1, 2'd2, 16'd5, 0, 0); idle(4, 2'd0);
    check("R9 counting after reload write", rdata_o, 16'd4);
    req = "R4"; pulses = 0;
    for (int i = 0; i < 12; i++) begin cyc(0, 2'd0, 0, 0, 0); pulses += upd_o; end
    check("R4 wrap pulses", 16'(pulses), 16'd2);
    req = "R3"; cyc(1, 2'd1, 16'd2, 0, 0); idle(3, 2'd1);
    check("R3 preload readback", rdata_o, 16'd2);
    req = "R2"; idle(6, 2'd0);
    req = "R5"; cyc(0, 2'd0, 0, 1, 0);
    check("R5 upd after strobe", {15'h0, upd_o}, 16'h1);
    check("R5 cleared", rdata_o, 16'h0);
    req = "R2"; idle(3, 2'd0);
    check("R2 divide by 3", rdata_o, 16'd1);
    req = "R6"; cyc(1, 2'd1, 16'd0, 0, 0); cyc(0, 2'd0, 0, 0, 1);
    check("R6 trig clears", rdata_o, 16'h0);
    idle(2, 2'd0);
    check("R6 new ratio", rdata_o, 16'd2);
    req = "R8"; cyc(1, 2'd0, 16'd5, 0, 0);
    check("R8 direct write", rdata_o, 16'd5);
    check("R8 no update", {15'h0, upd_o}, 16'h0);
    cyc(1, 2'd0, 16'd3, 1, 0);
    check("R8 strobe wins", rdata_o, 16'h0);
    req = "R10"; cyc(1, 2'd3, 16'hFFFF, 0, 0);
    check("R10 unused reads 0", rdata_o, 16'h0);
    cyc(0, 2'd2, 0, 0, 0);
    check("R10 reload untouched", rdata_o, 16'd5);
    cyc(0, 2'd1, 0, 0, 0);
    req = "R7"; cyc(1, 2'd2, 16'd0, 0, 0); idle(5, 2'd0);
    req = "R2";
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [1:0] a;
      logic [15:0] d;
      r = $urandom_range(0, 99);
      a = 2'($urandom_range(0, 3));
      d = (a == 2'd1) ? 16'($urandom_range(0, 3)) : 16'($urandom_range(0, 12));
      cyc(r < 8, a, d, r >= 95, r == 94);
    end
    finish_run();
  end
endmodule